// File: doc/BRIEF.md
# Cyclic Interrupt Challenge-Response Supervisor

This block watches over a host processor while the system sits in a low-power state with its supply still on. Once armed, it raises a short interrupt at the end of every period. After each interrupt the host has to prove it is alive before the next period ends. It does this by reading a fresh random byte from the block and writing back the bitwise inverse of that byte. If the proof is missing or wrong, the block stops cycling, holds the host in reset for a fixed number of ticks, and then parks in a Normal Request state. A dedicated wake command leaves the low-power state cleanly, without a reset.

The block receives command words that have already been deframed: a 16-bit word qualified by a one-clock valid strobe. It answers a code-read command with an 8-bit response byte. Time is counted in millisecond ticks from a one-clock tick input. The period is chosen by a period-select write, which is accepted only while the block is in Normal mode. The random byte comes from a free-running LFSR. It is captured at mode entry and at each interrupt, so the value the host reads stays fixed for the whole period.

Top module: `cyc_irq_sup`

## Requirements
- R1: After reset, mode_o is 0 (Normal; the encoding is 0 Normal, 1 low-power cyclic, 2 host reset, 3 Normal Request). irq_o, host_rst_o and resp_vld_o are low, and the period code is 0x0E.
- R2: A command whose high byte is 0x56 stores its low byte as the period code only while mode_o is 0. In every other mode it is ignored and the running period is unchanged.
- R3: Period codes 1 to 13 give a period of 2^code ticks. Code 0x0E, and every other code, gives 512 ticks.
- R4: The word 0x5C90 received in Normal mode enters the low-power cyclic mode (mode_o = 1). The first interrupt comes one full period of ticks after entry. irq_o is high for exactly one tick interval and only while mode_o is 1.
- R5: The word 0x1B00 returns the current random code on resp_byte_o, with resp_vld_o high on the clock after the command. The code is never zero, and it does not change within a period.
- R6: In the low-power cyclic mode, a command with high byte 0x5A whose low byte equals the inverse of the current code, sent after a code read in the same period, acknowledges that period, and the block keeps cycling.
- R7: No acknowledge is required in the period that follows entry. The first interrupt does not cause a fault.
- R8: If a period that began with an interrupt ends without a valid acknowledge, the block moves to mode 2 and asserts host_rst_o.
- R9: A 0x5A write whose low byte is not the inverse of the current code causes a fault (mode 2) on the next clock.
- R10: A 0x5A write in a period in which no code read has occurred causes a fault (mode 2) on the next clock.
- R11: host_rst_o stays high for 16 ticks. The block then enters mode 3 and stays there, ignoring further mode commands, until rst_n.
- R12: The word 0x5C10 received in the low-power cyclic mode moves the block directly to mode 3, and host_rst_o is never asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick_i | input | 1 | One-clock millisecond tick |
| cmd_vld_i | input | 1 | Command word valid strobe |
| cmd_word_i | input | 16 | Deframed command word |
| irq_o | output | 1 | Cyclic interrupt pulse to the host |
| host_rst_o | output | 1 | Host reset request |
| resp_vld_o | output | 1 | Response byte valid |
| resp_byte_o | output | 8 | Response byte (random code) |
| mode_o | output | 2 | Current mode |

## Verification
The assertions assume the following about the inputs:
- cmd_vld_i is a single-clock strobe carrying one whole word.
- ms_tick_i never stays high for more than one tick's worth of clocks.
- No acknowledge command lands on the same clock as the tick that closes a period.

The stimulus keeps within these assumptions. It drives the tick either on every clock or on every fourth clock, issues each command as a one-clock strobe on a falling edge, and starts every acknowledge a few clocks after the interrupt is seen, well inside the period.

// File: rtl/cis_pkg.sv
package cis_pkg;
   typedef enum logic [1:0] {
      MODE_NORMAL = 2'd0,
      MODE_LPCYC  = 2'd1,
      MODE_RESET  = 2'd2,
      MODE_NREQ   = 2'd3
   } cis_mode_e;

   localparam logic [7:0]  OP_PERIOD   = 8'h56;
   localparam logic [7:0]  OP_REFRESH  = 8'h5A;
   localparam logic [15:0] CMD_RDCODE  = 16'h1B00;
   localparam logic [15:0] CMD_LPCYC   = 16'h5C90;
   localparam logic [15:0] CMD_WAKE    = 16'h5C10;
   localparam logic [7:0]  PER_DEFAULT = 8'h0E;
   localparam int          DEF_TICKS   = 512;
endpackage

// File: rtl/cis_period_dec.sv
module cis_period_dec #(
   parameter int PERIOD_W = 14
) (
   input  logic [7:0]          code_i,
   output logic [PERIOD_W-1:0] limit_o
);
   localparam int MAX_POW = PERIOD_W - 1;

   if (PERIOD_W < 10 || PERIOD_W > 30) begin : g_chk_w
      $error("cis_period_dec: PERIOD_W must be within 10..30");
   end

   always_comb begin
      limit_o = PERIOD_W'(cis_pkg::DEF_TICKS - 1);
      for (int i = 1; i <= MAX_POW; i++) begin
         if (code_i == 8'(i)) begin
            limit_o = PERIOD_W'((64'd1 << i) - 64'd1);
         end
      end
   end
endmodule

// File: rtl/cis_lfsr.sv
module cis_lfsr #(
   parameter int         W    = 8,
   parameter logic [W-1:0] SEED = 8'h5B,
   parameter logic [W-1:0] TAPS = 8'hB8
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] value_o
);
   logic [W-1:0] state_q;
   logic [W-1:0] state_d;

   if (SEED == '0) begin : g_chk_seed
      $error("cis_lfsr: SEED must be nonzero");
   end
   if (TAPS[W-1] != 1'b1) begin : g_chk_taps
      $error("cis_lfsr: TAPS top bit must be set to keep the map invertible");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      if (b == W - 1) begin : g_top
         assign state_d[b] = TAPS[b] & state_q[0];
      end else begin : g_mid
         assign state_d[b] = state_q[b+1] ^ (TAPS[b] & state_q[0]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SEED;
      else        state_q <= state_d;
   end

   assign value_o = state_q;

   AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != '0); // R5
endmodule

// File: rtl/cis_tick_timer.sv
module cis_tick_timer #(
   parameter int PERIOD_W = 14
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run_i,
   input  logic                tick_i,
   input  logic [PERIOD_W-1:0] limit_i,
   output logic                end_o
);
   logic [PERIOD_W-1:0] cnt_q;

   assign end_o = run_i && tick_i && (cnt_q == limit_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (!run_i)     cnt_q <= '0;
      else if (end_o)      cnt_q <= '0;
      else if (tick_i)     cnt_q <= cnt_q + 1'b1;
   end

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      run_i |-> (cnt_q <= limit_i)); // R3
endmodule

// File: rtl/cyc_irq_sup.sv
module cyc_irq_sup
   import cis_pkg::*;
#(
   parameter int         PERIOD_W  = 14,
   parameter int         RST_TICKS = 16,
   parameter logic [7:0] LFSR_SEED = 8'h5B,
   parameter logic [7:0] LFSR_TAPS = 8'hB8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ms_tick_i,
   input  logic        cmd_vld_i,
   input  logic [15:0] cmd_word_i,
   output logic        irq_o,
   output logic        host_rst_o,
   output logic        resp_vld_o,
   output logic [7:0]  resp_byte_o,
   output logic [1:0]  mode_o
);
   localparam int RCNT_W = $clog2(RST_TICKS);

   if (RST_TICKS < 2) begin : g_chk_rst
      $error("cyc_irq_sup: RST_TICKS must be at least 2");
   end

   cis_mode_e           st_q, st_d;
   logic [7:0]          per_code_q;
   logic [7:0]          code_q;
   logic [7:0]          lfsr_val;
   logic [PERIOD_W-1:0] limit;
   logic                end_hit;
   logic                armed_q, rd_seen_q, ack_ok_q, irq_q;
   logic [RCNT_W-1:0]   rcnt_q;
   logic                resp_vld_q;
   logic [7:0]          resp_byte_q;

   // command decode
   logic [7:0] op_hi, op_lo;
   logic       is_rd, is_per, is_ref, is_lp, is_wake;
   logic       in_lp, entering, ref_good, ref_bad, timeout, rst_done;

   assign op_hi   = cmd_word_i[15:8];
   assign op_lo   = cmd_word_i[7:0];
   assign is_rd   = cmd_vld_i && (cmd_word_i == CMD_RDCODE);
   assign is_per  = cmd_vld_i && (op_hi == OP_PERIOD);
   assign is_ref  = cmd_vld_i && (op_hi == OP_REFRESH);
   assign is_lp   = cmd_vld_i && (cmd_word_i == CMD_LPCYC);
   assign is_wake = cmd_vld_i && (cmd_word_i == CMD_WAKE);

   assign in_lp    = (st_q == MODE_LPCYC);
   assign entering = (st_q == MODE_NORMAL) && is_lp;
   assign ref_good = in_lp && is_ref && rd_seen_q && (op_lo == ~code_q);
   assign ref_bad  = in_lp && is_ref && !ref_good;
   assign timeout  = end_hit && armed_q && !ack_ok_q;
   assign rst_done = ms_tick_i && (rcnt_q == RCNT_W'(RST_TICKS - 1));

   cis_period_dec #(.PERIOD_W(PERIOD_W)) u_dec (
      .code_i  (per_code_q),
      .limit_o (limit)
   );

   cis_tick_timer #(.PERIOD_W(PERIOD_W)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_i   (in_lp),
      .tick_i  (ms_tick_i),
      .limit_i (limit),
      .end_o   (end_hit)
   );

   cis_lfsr #(.W(8), .SEED(LFSR_SEED), .TAPS(LFSR_TAPS)) u_rng (
      .clk     (clk),
      .rst_n   (rst_n),
      .value_o (lfsr_val)
   );

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         MODE_NORMAL: if (is_lp) st_d = MODE_LPCYC;
         MODE_LPCYC: begin
            if (is_wake)                 st_d = MODE_NREQ;
            else if (ref_bad || timeout) st_d = MODE_RESET;
         end
         MODE_RESET:  if (rst_done) st_d = MODE_NREQ;
         MODE_NREQ:   st_d = MODE_NREQ;
         default:     st_d = MODE_NORMAL;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= MODE_NORMAL;
         per_code_q  <= PER_DEFAULT;
         code_q      <= LFSR_SEED;
         armed_q     <= 1'b0;
         rd_seen_q   <= 1'b0;
         ack_ok_q    <= 1'b0;
         irq_q       <= 1'b0;
         rcnt_q      <= '0;
         resp_vld_q  <= 1'b0;
         resp_byte_q <= '0;
      end else begin
         st_q <= st_d;

         if ((st_q == MODE_NORMAL) && is_per) per_code_q <= op_lo;

         if (entering || (in_lp && end_hit)) code_q <= lfsr_val;

         if (entering)     armed_q <= 1'b0;
         else if (end_hit) armed_q <= 1'b1;

         if (entering || end_hit)   rd_seen_q <= 1'b0;
         else if (in_lp && is_rd)   rd_seen_q <= 1'b1;

         if (entering || end_hit)   ack_ok_q <= 1'b0;
         else if (ref_good)         ack_ok_q <= 1'b1;

         if (st_d != MODE_LPCYC)    irq_q <= 1'b0;
         else if (end_hit)          irq_q <= 1'b1;
         else if (ms_tick_i)        irq_q <= 1'b0;

         if (st_q != MODE_RESET)    rcnt_q <= '0;
         else if (ms_tick_i)        rcnt_q <= rcnt_q + 1'b1;

         resp_vld_q <= is_rd;
         if (is_rd) resp_byte_q <= code_q;
      end
   end

   assign irq_o       = irq_q;
   assign host_rst_o  = (st_q == MODE_RESET);
   assign resp_vld_o  = resp_vld_q;
   assign resp_byte_o = resp_byte_q;
   assign mode_o      = st_q;

   AST_IRQ_ONLY_LP: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (mode_o == 2'd1)); // R4
   AST_PERIOD_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != MODE_NORMAL) |=> $stable(per_code_q)); // R2
   AST_CODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_lp && !end_hit) |=> $stable(code_q)); // R5
   AST_WAKE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (in_lp && is_wake) |=> ((mode_o == 2'd3) && !host_rst_o)); // R12
   AST_RST_THEN_NREQ: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(host_rst_o) |-> (mode_o == 2'd3)); // R11
   AST_NREQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'd3) |=> (mode_o == 2'd3)); // R11
   AST_BAD_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
      (in_lp && is_ref && !rd_seen_q && !is_wake) |=> host_rst_o); // R10
endmodule

// File: tb/cyc_irq_sup_tb.sv
module cyc_irq_sup_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ms_tick_i = 1'b0;
   logic        cmd_vld_i = 1'b0;
   logic [15:0] cmd_word_i = '0;
   logic        irq_o, host_rst_o, resp_vld_o;
   logic [7:0]  resp_byte_o;
   logic [1:0]  mode_o;

   int  n_chk = 0, n_bad = 0, cyc = 0;
   bit  tick_slow = 1'b0, done = 1'b0;
   int  tdiv = 0;
   logic       last_rv;
   logic [7:0] last_rb;

   localparam logic [7:0] VC [8] = '{8'h01, 8'h02, 8'h03, 8'h05, 8'h08, 8'h0A, 8'h0E, 8'h3F};
   localparam int         VT [8] = '{2, 4, 8, 32, 256, 1024, 512, 512};

   cyc_irq_sup u_dut (
      .clk(clk), .rst_n(rst_n), .ms_tick_i(ms_tick_i), .cmd_vld_i(cmd_vld_i),
      .cmd_word_i(cmd_word_i), .irq_o(irq_o), .host_rst_o(host_rst_o),
      .resp_vld_o(resp_vld_o), .resp_byte_o(resp_byte_o), .mode_o(mode_o)
   );

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk) begin
      tdiv = tdiv + 1;
      ms_tick_i = tick_slow ? (tdiv % 4 == 0) : 1'b1;
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic send(input logic [15:0] w);
      @(negedge clk);
      cmd_vld_i = 1'b1; cmd_word_i = w;
      @(negedge clk);
      cmd_vld_i = 1'b0; cmd_word_i = '0;
      last_rv = resp_vld_o; last_rb = resp_byte_o;
   endtask

   task automatic wait_irq(output int stamp);
      int n = 0;
      while (!irq_o && n < 20000) begin @(negedge clk); n++; end
      stamp = cyc;
   endtask

   task automatic enter_lp(input logic [7:0] code);
      do_reset();
      send({8'h56, code});
      send(16'h5C90);
   endtask

   task automatic ack(output logic [7:0] c);
      send(16'h1B00);
      c = last_rb;
      send({8'h5A, ~c});
   endtask

   initial begin
      int c0, s1, s2, s3, w;
      logic [7:0] cd, cd2;
      bit saw;

      do_reset();
      // R1 reset state
      check(mode_o == 2'd0, "R1 mode", mode_o, 0);
      check(!irq_o && !host_rst_o && !resp_vld_o, "R1 outputs", {irq_o, host_rst_o, resp_vld_o}, 0);
      send(16'h5C90);
      c0 = cyc;
      wait_irq(s1);
      check(s1 - c0 == 512, "R1 default period", s1 - c0, 512);

      // R3 table of period codes
      for (int k = 0; k < 8; k++) begin
         enter_lp(VC[k]);
         c0 = cyc;
         wait_irq(s1);
         check(s1 - c0 == VT[k], "R3 period", s1 - c0, VT[k]);
      end

      // R4 irq width with slow tick (4 ticks period = 16 clocks)
      tick_slow = 1'b1;
      enter_lp(8'h02);
      check(mode_o == 2'd1, "R4 mode after entry", mode_o, 1);
      wait_irq(s1);
      w = 0;
      while (irq_o) begin @(negedge clk); w++; end
      check(w == 4, "R4 irq width", w, 4);
      tick_slow = 1'b0;

      // R5 R6 R7 R2: acknowledge keeps cycling
      enter_lp(8'h04);
      wait_irq(s1);
      check(mode_o == 2'd1, "R7 no fault at first irq", mode_o, 1);
      send(16'h5601); // R2: ignored outside Normal
      send(16'h1B00);
      cd = last_rb;
      check(last_rv == 1'b1, "R5 resp valid", last_rv, 1);
      check(cd != 8'h00, "R5 code nonzero", cd, 1);
      send(16'h1B00);
      cd2 = last_rb;
      check(cd2 == cd, "R5 code stable", cd2, cd);
      send({8'h5A, ~cd});
      wait_irq(s2);
      check(s2 - s1 == 16, "R2 period unchanged", s2 - s1, 16);
      ack(cd);
      wait_irq(s3);
      check(mode_o == 2'd1 && !host_rst_o, "R6 still cycling", mode_o, 1);
      check(s3 - s2 == 16, "R6 second period", s3 - s2, 16);

      // R8 R11 missing acknowledge
      wait_irq(s1);
      while (!host_rst_o && cyc - s1 < 100) @(negedge clk);
      check(mode_o == 2'd2, "R8 fault mode", mode_o, 2);
      w = 0;
      while (host_rst_o && w < 100) begin @(negedge clk); w++; end
      check(w == 16, "R11 reset length", w, 16);
      check(mode_o == 2'd3, "R11 normal request", mode_o, 3);
      send(16'h5C90);
      repeat (5) @(negedge clk);
      check(mode_o == 2'd3, "R11 sticky", mode_o, 3);

      // R9 wrong inverse
      enter_lp(8'h04);
      wait_irq(s1);
      send(16'h1B00);
      cd = last_rb;
      send({8'h5A, ~cd ^ 8'h01});
      check(mode_o == 2'd2 && host_rst_o, "R9 wrong inverse", mode_o, 2);

      // R10 refresh without read
      enter_lp(8'h04);
      wait_irq(s1);
      send(16'h5A00);
      check(mode_o == 2'd2, "R10 refresh without read", mode_o, 2);

      // R12 wake
      enter_lp(8'h04);
      wait_irq(s1);
      send(16'h5C10);
      check(mode_o == 2'd3, "R12 wake mode", mode_o, 3);
      saw = 1'b0;
      for (int i = 0; i < 40; i++) begin @(negedge clk); if (host_rst_o) saw = 1'b1; end
      check(!saw, "R12 no reset pulse", saw, 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule